// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into a complete asynchronous serial frame on a single output line. A frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit that the block computes, then one or two high stop bits. The layout is chosen at run time through three static configuration inputs. These are captured when a request is accepted, so the frame already on the line is never disturbed by later changes.

Bit timing comes from an external baud divider as a one-cycle tick. Every bit boundary falls on a clock edge where the tick is high, so each bit lasts exactly one tick interval. A user raises `start` for one cycle while `busy` is low. `busy` stays high until the tick that closes the final stop bit. A `done` pulse then marks the end of the frame. A request that arrives in the very cycle of that closing tick is chained: its start bit follows the last stop bit with no idle gap.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever `busy` is low, `tx_line` is high, and `done` is low after reset.
- R2: When `start` is seen high in a cycle where `busy` is low and `baud_tick` is low, `busy` rises on the next edge. `tx_line` goes low as the start bit at the next edge with `baud_tick` high.
- R3: The data bits follow the start bit, least significant first. Their count is 5 + `cfg_len` (`cfg_len` 0..3 gives 5..8). `data_in` bits above that count are never sent.
- R4: `cfg_parity` = 01 selects even parity and 10 selects odd parity. One parity bit follows the last data bit. It makes the number of high bits among data plus parity even (01) or odd (10).
- R5: `cfg_parity` = 00 or 11 sends no parity slot at all. Frame lengths in bit times are therefore 8N1 = 10, 8E2 = 12, 7N1 = 9, 7O1 = 10 and 5N1 = 7.
- R6: After the data or parity bit come one high stop bit (`cfg_two_stop` = 0) or two (`cfg_two_stop` = 1).
- R7: `tx_line` changes only at a clock edge where `baud_tick` is high, so every bit lasts exactly one tick interval.
- R8: `busy` stays high until the edge of the tick that closes the final stop bit. `done` is high for exactly the one cycle after that edge.
- R9: A `start` pulse while `busy` is high (other than in the case of R10) is ignored. Changes of `data_in` and of the configuration inputs after acceptance do not alter the frame in flight.
- R10: A `start` seen in the same cycle as the tick that closes the final stop bit is accepted as the next frame. Its start bit begins at that edge with no idle bit, `busy` stays high, and `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle bit-boundary pulse from the external divider |
| start | input | 1 | Request to send `data_in` |
| data_in | input | 8 | Character to send, bit 0 first |
| cfg_len | input | 2 | Data length code, length = 5 + code |
| cfg_parity | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| tx_line | output | 1 | Serial output, high at rest |
| busy | output | 1 | A frame is pending or being sent |
| done | output | 1 | One-cycle pulse after the final stop bit ends |

## Verification
The end of one frame and the acceptance of the next can fall on the same edge. This happens when a request is raised in the cycle that carries the tick closing the last stop bit. The bench provokes it by watching the tick during the final stop bit and asserting `start` together with it. It then judges that, right after that edge, `done` is high, `busy` stays high and `tx_line` already carries the new start bit. The rest of the chained frame, sent with a different length, parity and stop count, must then match its own expected bit sequence.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } utx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } utx_par_e;

endpackage

// File: rtl/utx_parity_gen.sv
module utx_parity_gen #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [1:0]        mode,
    output logic              par_en,
    output logic              par_bit
);
    import utx_pkg::*;

    logic [DATA_W-1:0] mask;
    logic              ones_odd;

    // Positions below MIN_LEN always count; higher ones depend on the length code.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        if (g < MIN_LEN) begin : g_fixed
            assign mask[g] = 1'b1;
        end else begin : g_coded
            assign mask[g] = (32'(len_code) > (g - MIN_LEN));
        end
    end

    assign ones_odd = ^(data & mask);
    assign par_en   = (mode == PAR_EVEN) || (mode == PAR_ODD);
    assign par_bit  = (mode == PAR_ODD) ? ~ones_odd : ones_odd;

endmodule

// File: rtl/utx_frame_fsm.sv
module utx_frame_fsm #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              par_en,
    input  logic              par_bit,
    input  logic              two_stop,
    output logic              line,
    output logic              busy,
    output logic              done
);
    import utx_pkg::*;

    localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(MIN_LEN - 1);

    typedef struct packed {
        utx_state_e        st;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  last;
        logic              par_en;
        logic              par_bit;
        logic              two_stop;
        logic              line;
        logic              done;
    } fsm_t;

    localparam fsm_t FSM_RST = '{ST_IDLE, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    fsm_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.shreg    = data;
                    d.last     = LAST_BASE + CNT_W'(len_code);
                    d.par_en   = par_en;
                    d.par_bit  = par_bit;
                    d.two_stop = two_stop;
                    d.st       = ST_ARM;
                end
            end
            ST_ARM: begin
                if (tick) begin
                    d.st   = ST_START;
                    d.line = 1'b0;
                end
            end
            ST_START: begin
                if (tick) begin
                    d.st    = ST_DATA;
                    d.line  = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                    d.cnt   = '0;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == q.last) begin
                        d.cnt = '0;
                        if (q.par_en) begin
                            d.st   = ST_PAR;
                            d.line = q.par_bit;
                        end else begin
                            d.st   = ST_STOP;
                            d.line = 1'b1;
                        end
                    end else begin
                        d.cnt   = q.cnt + 1'b1;
                        d.line  = q.shreg[0];
                        d.shreg = q.shreg >> 1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    d.st   = ST_STOP;
                    d.line = 1'b1;
                    d.cnt  = '0;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.two_stop && (q.cnt == '0)) begin
                        d.cnt = CNT_W'(1);
                    end else begin
                        d.done = 1'b1;
                        if (start) begin
                            d.shreg    = data;
                            d.last     = LAST_BASE + CNT_W'(len_code);
                            d.par_en   = par_en;
                            d.par_bit  = par_bit;
                            d.two_stop = two_stop;
                            d.st       = ST_START;
                            d.line     = 1'b0;
                        end else begin
                            d.st   = ST_IDLE;
                            d.line = 1'b1;
                        end
                    end
                end
            end
            default: d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= FSM_RST;
        end else begin
            q <= d;
        end
    end

    assign line = q.line;
    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    output logic              tx_line,
    output logic              busy,
    output logic              done
);
    localparam int LEN_W = 2;
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic par_en;
    logic par_bit;

    utx_parity_gen #(
        .DATA_W (DATA_W),
        .MIN_LEN(MIN_LEN),
        .LEN_W  (LEN_W)
    ) u_par (
        .data    (data_in),
        .len_code(cfg_len),
        .mode    (cfg_parity),
        .par_en  (par_en),
        .par_bit (par_bit)
    );

    utx_frame_fsm #(
        .DATA_W (DATA_W),
        .MIN_LEN(MIN_LEN),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .start   (start),
        .data    (data_in),
        .len_code(cfg_len),
        .par_en  (par_en),
        .par_bit (par_bit),
        .two_stop(cfg_two_stop),
        .line    (tx_line),
        .busy    (busy),
        .done    (done)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic start,
    input logic tx_line,
    input logic busy,
    input logic done
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line); // R1

    AST_LINE_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_line)); // R7

    AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !baud_tick |=> busy); // R8

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R8

    AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tx_line) && $past(baud_tick))); // R6

    AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_tick(baud_tick),
    .start    (start),
    .tx_line  (tx_line),
    .busy     (busy),
    .done     (done)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       start = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [1:0] cfg_len = 2'b00;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       tx_line;
    logic       busy;
    logic       done;

    logic       tick_seen = 1'b0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    uart_frame_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .start       (start),
        .data_in     (data_in),
        .cfg_len     (cfg_len),
        .cfg_parity  (cfg_parity),
        .cfg_two_stop(cfg_two_stop),
        .tx_line     (tx_line),
        .busy        (busy),
        .done        (done)
    );

    initial forever #2.5 clk = ~clk;

    // Tick every 8 cycles; tick_seen tells whether the edge just passed carried a tick.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            tick_seen = baud_tick;
            cnt = (cnt == 7) ? 0 : cnt + 1;
            baud_tick = (cnt == 7);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] pm,
                         input logic two, output logic [15:0] e, output int n);
        int  len;
        logic p;
        len = 5 + int'(lc);
        e = '1;
        p = 1'b0;
        e[0] = 1'b0;
        n = 1;
        for (int i = 0; i < len; i++) begin
            e[n] = d[i];
            p = p ^ d[i];
            n++;
        end
        if (pm == 2'b01) begin
            e[n] = p;
            n++;
        end else if (pm == 2'b10) begin
            e[n] = ~p;
            n++;
        end
        e[n] = 1'b1;
        n++;
        if (two) begin
            e[n] = 1'b1;
            n++;
        end
    endtask

    task automatic wait_bnd();
        bit got;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            #1;
            got = tick_seen;
        end
    endtask

    task automatic drive(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] pm,
                         input logic two, input logic s);
        data_in      = d;
        cfg_len      = lc;
        cfg_parity   = pm;
        cfg_two_stop = two;
        start        = s;
    endtask

    task automatic issue(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] pm, input logic two);
        @(negedge clk);
        #1;
        while (baud_tick) begin
            @(negedge clk);
            #1;
        end
        drive(d, lc, pm, two, 1'b1);
        @(negedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic check_frame(input string req, input logic [15:0] e, input int n, input int first,
                               input bit disturb, input bit end_check);
        for (int k = first; k < n; k++) begin
            wait_bnd();
            chk(req, $sformatf("bit %0d", k), 32'(tx_line), 32'(e[k]));
            chk({req, " R8"}, "busy in frame", 32'(busy), 32'd1);
            if (disturb && k == 3) begin
                drive(8'h5A, 2'b00, 2'b00, 1'b0, 1'b1); // R9 ignored request with new config
                @(negedge clk);
                #1;
                start = 1'b0;
            end
            repeat (3) @(negedge clk);
            #1;
            chk({req, " R7"}, $sformatf("mid bit %0d", k), 32'(tx_line), 32'(e[k]));
        end
        if (end_check) begin
            wait_bnd();
            chk("R8", "busy after frame", 32'(busy), 32'd0);
            chk("R8", "done pulse", 32'(done), 32'd1);
            chk("R1", "line idle", 32'(tx_line), 32'd1);
            @(negedge clk);
            #1;
            chk("R8", "done one cycle", 32'(done), 32'd0);
        end
    endtask

    task automatic t_frame(input string req, input logic [7:0] d, input logic [1:0] lc,
                           input logic [1:0] pm, input logic two, input int exp_len);
        logic [15:0] e;
        int n;
        build(d, lc, pm, two, e, n);
        chk({req, " R5"}, "frame length model", n, exp_len);
        issue(d, lc, pm, two);
        check_frame(req, e, n, 0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1", "reset line", 32'(tx_line), 32'd1);
        chk("R1", "reset busy", 32'(busy), 32'd0);
        chk("R1", "reset done", 32'(done), 32'd0);
    endtask

    task automatic t_ignore();
        logic [15:0] e;
        int n;
        build(8'hE1, 2'b11, 2'b10, 1'b1, e, n);
        issue(8'hE1, 2'b11, 2'b10, 1'b1);
        check_frame("R9", e, n, 0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            wait_bnd();
            chk("R9", "no extra frame busy", 32'(busy), 32'd0);
            chk("R9", "no extra frame line", 32'(tx_line), 32'd1);
        end
    endtask

    task automatic t_chain();
        logic [15:0] ea;
        logic [15:0] eb;
        int na;
        int nb;
        bit got;
        build(8'hC3, 2'b11, 2'b00, 1'b0, ea, na);
        build(8'h16, 2'b00, 2'b01, 1'b1, eb, nb);
        issue(8'hC3, 2'b11, 2'b00, 1'b0);
        check_frame("R10", ea, na, 0, 1'b0, 1'b0);
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            #1;
            if (baud_tick) begin
                drive(8'h16, 2'b00, 2'b01, 1'b1, 1'b1);
                got = 1'b1;
            end
        end
        wait_bnd();
        start = 1'b0;
        chk("R10", "done at chain", 32'(done), 32'd1);
        chk("R10", "busy held at chain", 32'(busy), 32'd1);
        chk("R10", "start bit without gap", 32'(tx_line), 32'd0);
        check_frame("R10", eb, nb, 1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        t_frame("R2/R3 8N1",   8'hA5, 2'b11, 2'b00, 1'b0, 10);
        t_frame("R4/R6 8E2",   8'h37, 2'b11, 2'b01, 1'b1, 12);
        t_frame("R3/R5 7N1",   8'h80, 2'b10, 2'b00, 1'b0, 9);
        t_frame("R4 7O1",      8'h55, 2'b10, 2'b10, 1'b0, 10);
        t_frame("R3/R5 5N1",   8'hFF, 2'b00, 2'b00, 1'b0, 7);
        t_frame("R4 6E1",      8'h2C, 2'b01, 2'b01, 1'b0, 9);
        t_frame("R5 code 11",  8'h0F, 2'b11, 2'b11, 1'b0, 10);
        t_ignore();
        t_chain();
        finish_run();
    end

endmodule